// File: doc/BRIEF.md
# Split-Period Edge-Selecting Frequency Divider

This divider sits in the feedback path of a fractional-N loop whose total divide value changes every reference cycle. It is clocked by the high-speed oscillator clock. Each divide period is cut into four back-to-back sub-periods, so the internal counter wraps at four times the reference rate. Three of the sub-periods have a fixed length. One of them (the third, by default) absorbs whatever is left of the requested total. Only the edge that closes the last sub-period is forwarded to the time-to-digital converter. That forwarded edge therefore always follows a counter run of the same length, whatever value the modulator supplied. This removes the dependence of divider delay on the dithered value.

Divide values arrive as a valid/ready stream. The block asserts `div_ready` for exactly one clock: the cycle that closes a period, or the first cycle after reset. A value offered while `div_ready` is low is not taken, and the producer must hold it. If no value is offered in the ready cycle, the previous total is used again, so the divider never stalls. The forwarded edge is a plain pulse with no back-pressure.

Top module: `sped_divider`

## Requirements
- R1: While reset is held, `div_out` and `sub_out` are low and `div_ready` is high. The first clock after reset starts a period and raises no output pulse.
- R2: Every accepted total T produces a period of exactly T clocks. That is the number of clocks from the ready cycle in which T was taken to the cycle in which `div_out` is high, counting the latter but not the former.
- R3: `div_ready` is high only in the cycle that closes a period (the `div_out` cycle) and in the first cycle after reset. A value presented in any other cycle has no effect on the period lengths.
- R4: If `div_valid` is low in a ready cycle, the next period reuses the previously accepted total.
- R5: A requested value below 64 is treated as 64, and a value above 127 is treated as 127. With the 8-bit `div_value` port, this covers values 0 to 255.
- R6: `div_out` is a single-clock pulse, high only in the cycle that closes the fourth sub-period, and never in two consecutive cycles.
- R7: `sub_out` pulses at the end of each sub-period: 16, 32, T-16 and T clocks into a period of total T. The first, second and fourth sub-periods are always 16 clocks long.
- R8: Until a value has been accepted, the divider runs with a total of 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_valid | input | 1 | A divide value is offered |
| div_ready | output | 1 | The value is taken at this clock edge |
| div_value | input | 8 | Requested total divide value |
| div_out | output | 1 | Forwarded edge, one pulse per divide period |
| sub_out | output | 1 | End of every sub-period (four per period) |

## Verification
The assertions assume the total can always be split into sub-periods of at least one clock. This holds because the smallest total is four times the fixed sub-period length. They also assume the stream partner obeys the one-cycle ready window. The stimulus keeps the valid line and the value changing randomly in every cycle, including cycles where ready is low, so values offered outside the window must be ignored. It sends raw values across the whole 8-bit range, so clamping is exercised at both ends. Directed values at the start cover the reset default, the two range limits and a skipped offer.

// File: rtl/sped_pkg.sv
package sped_pkg;
  localparam int SLOTS = 4;
  typedef enum logic [1:0] {
    SLOT_HEAD  = 2'd0,
    SLOT_EARLY = 2'd1,
    SLOT_FREE  = 2'd2,
    SLOT_TAIL  = 2'd3
  } slot_e;
endpackage

// File: rtl/sped_down_counter.sv
module sped_down_counter #(
  parameter int CW     = 7,
  parameter int LEN_MAX = 127
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] load_len,
  output logic          tc
);
  logic [CW-1:0] cnt_q;

  assign tc = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (tc) cnt_q <= load_len - CW'(1);
    else         cnt_q <= cnt_q - CW'(1);
  end

  // R7: a reloaded sub-count never exceeds the longest legal sub-period
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LEN_MAX));

  // R7: every sub-period is at least one clock, so the reload never wraps
  assert_len_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (load_len != '0));
endmodule

// File: rtl/sped_slot_seq.sv
module sped_slot_seq
  import sped_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tc,
  output slot_e slot,
  output slot_e slot_next,
  output logic  started,
  output logic  boundary
);
  slot_e slot_q;
  logic  started_q;

  assign slot      = slot_q;
  assign slot_next = slot_e'(slot_q + 2'd1);
  assign started   = started_q;
  assign boundary  = tc && (slot_q == SLOT_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q    <= SLOT_TAIL;
      started_q <= 1'b0;
    end else if (tc) begin
      slot_q    <= slot_next;
      started_q <= 1'b1;
    end
  end

  // R6: the slot index moves by exactly one per terminal count
  assert_slot_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> (slot_q == slot_e'($past(slot_q) + 2'd1)));

  // R3: the index only moves at a terminal count
  assert_slot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(slot_q));
endmodule

// File: rtl/sped_value_latch.sv
module sped_value_latch #(
  parameter int DW        = 8,
  parameter int CW        = 7,
  parameter int DIV_MIN   = 64,
  parameter int DIV_MAX   = 127,
  parameter int DIV_RESET = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          in_valid,
  input  logic [DW-1:0] in_value,
  output logic          in_ready,
  output logic [CW-1:0] total_next,
  output logic [CW-1:0] total_q
);
  logic [CW-1:0] clamped;
  logic          take;

  always_comb begin
    if (in_value < DW'(DIV_MIN))      clamped = CW'(DIV_MIN);
    else if (in_value > DW'(DIV_MAX)) clamped = CW'(DIV_MAX);
    else                              clamped = in_value[CW-1:0];
  end

  assign in_ready   = boundary;
  assign take       = in_valid && boundary;
  assign total_next = take ? clamped : total_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    total_q <= CW'(DIV_RESET);
    else if (take) total_q <= clamped;
  end

  // R5: the held total always lies within the supported range
  assert_total_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (total_q >= CW'(DIV_MIN)) && (total_q <= CW'(DIV_MAX)));

  // R3 / R4: the held total changes only through an accepted transfer
  assert_total_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(total_q));
endmodule

// File: rtl/sped_divider.sv
module sped_divider #(
  parameter int DW          = 8,
  parameter int DIV_MIN     = 64,
  parameter int DIV_MAX     = 127,
  parameter int DIV_RESET   = 64,
  parameter int DITHER_SLOT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          div_valid,
  output logic          div_ready,
  input  logic [DW-1:0] div_value,
  output logic          div_out,
  output logic          sub_out
);
  import sped_pkg::*;

  localparam int CW      = $clog2(DIV_MAX + 1);
  localparam int FIX_LEN = DIV_MIN / SLOTS;
  localparam int VAR_MIN = DIV_MIN - (SLOTS - 1) * FIX_LEN;
  localparam int VAR_MAX = DIV_MAX - (SLOTS - 1) * FIX_LEN;

  logic          tc;
  logic          started;
  logic          boundary;
  slot_e         slot;
  slot_e         slot_next;
  logic [CW-1:0] total_next;
  logic [CW-1:0] total_q;
  logic [CW-1:0] var_len;
  logic [CW-1:0] sub_len [SLOTS];
  logic [CW-1:0] load_len;

  sped_value_latch #(
    .DW(DW), .CW(CW), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX), .DIV_RESET(DIV_RESET)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .boundary(boundary),
    .in_valid(div_valid), .in_value(div_value), .in_ready(div_ready),
    .total_next(total_next), .total_q(total_q)
  );

  sped_slot_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tc(tc), .slot(slot), .slot_next(slot_next),
    .started(started), .boundary(boundary)
  );

  assign var_len = total_next - CW'((SLOTS - 1) * FIX_LEN);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s == DITHER_SLOT) begin : g_var
      assign sub_len[s] = var_len;
    end else begin : g_fix
      assign sub_len[s] = CW'(FIX_LEN);
    end
  end

  assign load_len = sub_len[slot_next];

  sped_down_counter #(.CW(CW), .LEN_MAX(VAR_MAX)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_len(load_len), .tc(tc)
  );

  assign sub_out = tc && started;
  assign div_out = boundary && started;

  // checker state: clocks since the last period start and last sub edge
  logic [CW:0] run_q;
  logic [CW:0] sub_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      sub_run_q <= '0;
    end else begin
      run_q     <= boundary ? (CW+1)'(1) : run_q + (CW+1)'(1);
      sub_run_q <= tc ? (CW+1)'(1) : sub_run_q + (CW+1)'(1);
    end
  end

  // R2: the forwarded edge arrives exactly one total after the period began
  assert_period_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |-> (run_q == {1'b0, total_q}));

  // R7: fixed sub-periods (including the one ending at the forwarded edge) are constant
  assert_fixed_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_out && (int'(slot) != DITHER_SLOT)) |-> (sub_run_q == (CW+1)'(FIX_LEN)));

  // R6: the forwarded edge is one clock wide and coincides with a sub edge
  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);
  assert_pulse_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |-> (sub_out && slot == SLOT_TAIL));

  // R5: the free sub-period stays inside its derived range
  assert_var_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (var_len >= CW'(VAR_MIN)) && (var_len <= CW'(VAR_MAX)));
endmodule

// File: tb/test_sped_divider.sv
module test_sped_divider;
  localparam int DMIN = 64;
  localparam int DMAX = 127;
  localparam int DRST = 64;
  localparam int FIX  = 16;
  localparam int NCYC = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [7:0] val = 8'd0;
  logic       rdy, dout, sout;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sped_divider i_sped_divider (
    .clk(clk), .rst_n(rst_n), .div_valid(vld), .div_ready(rdy),
    .div_value(val), .div_out(dout), .sub_out(sout)
  );

  function automatic int clampv(int v);
    if (v < DMIN) return DMIN;
    if (v > DMAX) return DMAX;
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int    t, T, nb;
    bit    first;
    bit    bnd;
    string ptag;
    int    dir[8];
    void'($urandom(32'd1234));
    // -1: no offer in the ready cycle
    dir = '{-1, 127, 64, 200, 10, -1, 126, 96};
    t = 0; T = DRST; nb = 0; first = 1'b1; ptag = "R8";

    repeat (3) @(negedge clk);
    chk("R1", dout, 0);
    chk("R1", sout, 0);
    chk("R1", rdy, 1);
    rst_n = 1'b1;

    for (int c = 0; c < NCYC; c++) begin
      bnd = first ? 1'b1 : (t == T);
      chk("R3", rdy, bnd);
      chk(first ? "R1" : ptag, dout, (!first && t == T) ? 1 : 0);
      chk("R7", sout, (!first && (t == FIX || t == 2*FIX || t == T-FIX || t == T)) ? 1 : 0);
      chk("R6", dout & ~sout, 0);

      if (bnd && nb < 8) begin
        vld = (dir[nb] >= 0);
        val = (dir[nb] >= 0) ? 8'(dir[nb]) : 8'($urandom_range(0, 255));
      end else begin
        vld = ($urandom_range(0, 9) < 6);
        val = 8'($urandom_range(0, 255));
      end

      if (bnd) begin
        if (vld) begin
          T = clampv(int'(val));
          ptag = (int'(val) < DMIN || int'(val) > DMAX) ? "R5" : "R2";
        end else begin
          ptag = (nb == 0) ? "R8" : "R4";
        end
        t = 1;
        first = 1'b0;
        nb++;
      end else begin
        t++;
      end
      @(negedge clk);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule